// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block is a memory-mapped peripheral with three independent up-counting timers behind one register window. Every timer has six word registers: a clock configuration word, a counter configuration word, a read-only count, an interval limit, a pending-event word and an event-enable word. The copies of a register kind for the three timers sit at consecutive words, so timer n's copy is at the kind's base offset plus 4·n.

Each counter is advanced by a power-of-two prescaler or by every clock. It either runs freely and wraps at its all-ones value, or it runs up to the interval limit and starts again from zero. Both of these events set a pending flag. A pending flag clears when software reads the pending-event word. The interrupt line of a timer is high while any pending flag that is enabled is set. Software starts a timer by writing the restart bit, which zeroes the count, and can clear the hold bit in the same write.

Top module: `triad_timer`

## Requirements
- R1: After reset every count, interval, pending and enable word is 0, the clock configuration word is 0, the counter configuration word reads 0x01 (hold set), and every interrupt line is low.
- R2: Word registers are decoded by byte offset: clock configuration 0x00, counter configuration 0x0C, count 0x18, interval 0x24, pending 0x54, enable 0x60, each plus 4·n for timer n. A write reaches only the addressed timer, and a read of any other offset returns 0.
- R3: While counter configuration bit 0 (hold) is 1, the count keeps its value. The count also stops at the edge after the write that sets hold.
- R4: A write with counter configuration bit 4 set zeroes the count and the prescaler at the write edge, even when hold stays set. The same write may clear hold. Bit 4 always reads back as 0.
- R5: With clock configuration bit 0 clear, the count advances on every clock. With bit 0 set, it advances once every 2^(N+1) clocks, where N is clock configuration bits 4:1.
- R6: With counter configuration bit 1 clear (free mode), the count goes from all ones (0xFFFF for 16 bits) to 0, and pending bit 1 (overflow) is set at that edge.
- R7: With counter configuration bit 1 set (interval mode), the count goes from the interval value to 0, and pending bit 0 (interval) is set at that edge. The period is therefore (interval+1) count steps.
- R8: A read of a pending word returns its value before the read and clears it at the read edge.
- R9: An event that occurs at the same edge as a pending read stays set after that read.
- R10: The interrupt line n is registered and updates at the same edge as the pending and enable words. It equals the OR of pending bits ANDed with enable bits (bit 0 interval, bit 1 overflow).
- R11: Read data is registered and shows the addressed register as it was at the edge that samples the read. Clock configuration bit 5 and counter configuration bit 5 are stored and read back but do not change counting.
- R12: Writes to the count offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the word register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | NUM | Interrupt line per timer |

## Verification
A write takes effect at the clock edge that samples it, and read data appears one edge after the read strobe. That data holds the register value from just before the sampling edge. After a restart at edge W, the count at a read sampled at edge R is floor((R−1−W)/D), where D is the prescale divisor. An interval event lands at edge W+(I+1)·D, and a wrap lands at edge W+2^16·D. The interrupt rises at the same edge as its event. The bench counts rising edges with a free-running counter and records the edge number of every write and read. Each expected count, event edge and pending value is computed from those numbers, and outputs are sampled on the falling edge that follows. The read-clear collision is hit by timing a pending read so that it is sampled on a computed event edge.

// File: rtl/triad_timer_pkg.sv
package triad_timer_pkg;

  // register kinds inside the window
  localparam int K_CLK = 0;
  localparam int K_CTL = 1;
  localparam int K_VAL = 2;
  localparam int K_IVL = 3;
  localparam int K_STS = 4;
  localparam int K_IER = 5;
  localparam int KIND_N = 6;

  // configuration word width held per register
  localparam int CFG_W = 6;

  // clock configuration bits
  localparam int CK_PRE_EN  = 0;
  localparam int CK_PSV_LSB = 1;
  localparam int CK_PSV_W   = 4;
  localparam int CK_SRC     = 5;

  // counter configuration bits
  localparam int CT_HOLD    = 0;
  localparam int CT_IVL     = 1;
  localparam int CT_RESTART = 4;
  localparam int CT_SPARE   = 5;

  // pending bits
  localparam int EV_IVL = 0;
  localparam int EV_OVF = 1;
  localparam int EV_W   = 2;

  // word index of each kind for timer 0
  function automatic logic [31:0] kind_base(input int kind);
    case (kind)
      K_CLK:   return 32'd0;
      K_CTL:   return 32'd3;
      K_VAL:   return 32'd6;
      K_IVL:   return 32'd9;
      K_STS:   return 32'd21;
      K_IER:   return 32'd24;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/triad_timer_prescale.sv
module triad_timer_prescale #(
  parameter int PSV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic             pre_en,
  input  logic [PSV_W-1:0] psv,
  output logic             tick
);

  localparam int DIV_W = (1 << PSV_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_v;
  logic             at_last;

  assign last_v  = (DIV_W'(2) << psv) - DIV_W'(1);
  // a shrinking divisor must not strand the divider above its new limit
  assign at_last = (div_q >= last_v);
  assign tick    = run && (!pre_en || at_last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q <= '0;
    end else if (run) begin
      if (!pre_en || at_last) div_q <= '0;
      else                    div_q <= div_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/triad_timer_chan.sv
module triad_timer_chan
  import triad_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [CNT_W-1:0]     ivl_wdata,
  input  logic                 we_clk,
  input  logic                 we_ctl,
  input  logic                 we_ivl,
  input  logic                 we_ier,
  input  logic                 rd_sts,
  output logic [CFG_W-1:0]     clk_cfg,
  output logic [CFG_W-1:0]     ctl_cfg,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     ivl,
  output logic [EV_W-1:0]      sts,
  output logic [EV_W-1:0]      ier,
  output logic                 irq,
  output logic                 tick,
  output logic [EV_W-1:0]      evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                pre_en_q, src_q;
  logic [CK_PSV_W-1:0] psv_q;
  logic                hold_q, mode_q, spare_q;
  logic [CNT_W-1:0]    cnt_q, cnt_d, ivl_q;
  logic [EV_W-1:0]     sts_q, sts_d, ier_q, ier_d;
  logic                irq_q;
  logic                restart, hit_ivl, hit_ovf;

  assign restart = we_ctl && cfg_wdata[CT_RESTART];

  triad_timer_prescale #(.PSV_W(CK_PSV_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (!hold_q),
    .clear  (restart),
    .pre_en (pre_en_q),
    .psv    (psv_q),
    .tick   (tick)
  );

  always_comb begin
    hit_ivl = tick && mode_q && (cnt_q == ivl_q);
    hit_ovf = tick && !mode_q && (cnt_q == CNT_MAX);
    evt     = '0;
    if (!restart) begin
      evt[EV_IVL] = hit_ivl;
      evt[EV_OVF] = hit_ovf;
    end
    if (restart)                 cnt_d = '0;
    else if (hit_ivl || hit_ovf) cnt_d = '0;
    else if (tick)               cnt_d = cnt_q + CNT_W'(1);
    else                         cnt_d = cnt_q;
    sts_d = (rd_sts ? '0 : sts_q) | evt;
    ier_d = we_ier ? cfg_wdata[EV_W-1:0] : ier_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q <= 1'b0;
      psv_q    <= '0;
      src_q    <= 1'b0;
      hold_q   <= 1'b1;
      mode_q   <= 1'b0;
      spare_q  <= 1'b0;
      ivl_q    <= '0;
      cnt_q    <= '0;
      sts_q    <= '0;
      ier_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (we_clk) begin
        pre_en_q <= cfg_wdata[CK_PRE_EN];
        psv_q    <= cfg_wdata[CK_PSV_LSB +: CK_PSV_W];
        src_q    <= cfg_wdata[CK_SRC];
      end
      if (we_ctl) begin
        hold_q  <= cfg_wdata[CT_HOLD];
        mode_q  <= cfg_wdata[CT_IVL];
        spare_q <= cfg_wdata[CT_SPARE];
      end
      if (we_ivl) ivl_q <= ivl_wdata;
      cnt_q <= cnt_d;
      sts_q <= sts_d;
      ier_q <= ier_d;
      irq_q <= |(sts_d & ier_d);
    end
  end

  assign clk_cfg = {src_q, psv_q, pre_en_q};
  assign ctl_cfg = {spare_q, 1'b0, 2'b00, mode_q, hold_q};
  assign count   = cnt_q;
  assign ivl     = ivl_q;
  assign sts     = sts_q;
  assign ier     = ier_q;
  assign irq     = irq_q;

endmodule

// File: rtl/triad_timer_bus.sv
module triad_timer_bus
  import triad_timer_pkg::*;
#(
  parameter int NUM    = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [NUM-1:0][CFG_W-1:0]   clk_cfg,
  input  logic [NUM-1:0][CFG_W-1:0]   ctl_cfg,
  input  logic [NUM-1:0][CNT_W-1:0]   count,
  input  logic [NUM-1:0][CNT_W-1:0]   ivl,
  input  logic [NUM-1:0][EV_W-1:0]    sts,
  input  logic [NUM-1:0][EV_W-1:0]    ier,
  output logic [NUM-1:0]              we_clk,
  output logic [NUM-1:0]              we_ctl,
  output logic [NUM-1:0]              we_ivl,
  output logic [NUM-1:0]              we_ier,
  output logic [NUM-1:0]              rd_sts,
  output logic [DATA_W-1:0]           bus_rdata
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]             widx;
  logic [KIND_N-1:0][NUM-1:0]    hit;
  logic [DATA_W-1:0]             rd_mux, rdata_q;

  assign widx = bus_addr[ADDR_W-1:2];

  for (genvar gk = 0; gk < KIND_N; gk++) begin : g_kind
    for (genvar gn = 0; gn < NUM; gn++) begin : g_tmr
      assign hit[gk][gn] = (32'(widx) == kind_base(gk) + 32'(gn));
    end
  end

  assign we_clk = {NUM{bus_wr}} & hit[K_CLK];
  assign we_ctl = {NUM{bus_wr}} & hit[K_CTL];
  assign we_ivl = {NUM{bus_wr}} & hit[K_IVL];
  assign we_ier = {NUM{bus_wr}} & hit[K_IER];
  assign rd_sts = {NUM{bus_rd}} & hit[K_STS];

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM; n++) begin
      if (hit[K_CLK][n]) rd_mux = rd_mux | DATA_W'(clk_cfg[n]);
      if (hit[K_CTL][n]) rd_mux = rd_mux | DATA_W'(ctl_cfg[n]);
      if (hit[K_VAL][n]) rd_mux = rd_mux | DATA_W'(count[n]);
      if (hit[K_IVL][n]) rd_mux = rd_mux | DATA_W'(ivl[n]);
      if (hit[K_STS][n]) rd_mux = rd_mux | DATA_W'(sts[n]);
      if (hit[K_IER][n]) rd_mux = rd_mux | DATA_W'(ier[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/triad_timer.sv
module triad_timer
  import triad_timer_pkg::*;
#(
  parameter int NUM    = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM-1:0]    irq
);

  logic [NUM-1:0][CFG_W-1:0] clk_cfg_all, ctl_cfg_all;
  logic [NUM-1:0][CNT_W-1:0] cnt_all, ivl_all;
  logic [NUM-1:0][EV_W-1:0]  sts_all, ier_all, evt_all;
  logic [NUM-1:0]            we_clk, we_ctl, we_ivl, we_ier, rd_sts, tick_all;
  logic                      unused_bus;

  assign unused_bus = ^{bus_addr[1:0], bus_wdata};

  triad_timer_bus #(
    .NUM(NUM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .clk_cfg   (clk_cfg_all),
    .ctl_cfg   (ctl_cfg_all),
    .count     (cnt_all),
    .ivl       (ivl_all),
    .sts       (sts_all),
    .ier       (ier_all),
    .we_clk    (we_clk),
    .we_ctl    (we_ctl),
    .we_ivl    (we_ivl),
    .we_ier    (we_ier),
    .rd_sts    (rd_sts),
    .bus_rdata (bus_rdata)
  );

  for (genvar gi = 0; gi < NUM; gi++) begin : g_chan
    triad_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_wdata (bus_wdata[CFG_W-1:0]),
      .ivl_wdata (bus_wdata[CNT_W-1:0]),
      .we_clk    (we_clk[gi]),
      .we_ctl    (we_ctl[gi]),
      .we_ivl    (we_ivl[gi]),
      .we_ier    (we_ier[gi]),
      .rd_sts    (rd_sts[gi]),
      .clk_cfg   (clk_cfg_all[gi]),
      .ctl_cfg   (ctl_cfg_all[gi]),
      .count     (cnt_all[gi]),
      .ivl       (ivl_all[gi]),
      .sts       (sts_all[gi]),
      .ier       (ier_all[gi]),
      .irq       (irq[gi]),
      .tick      (tick_all[gi]),
      .evt       (evt_all[gi])
    );
  end

endmodule

// File: rtl/triad_timer_chk.sv
module triad_timer_chk
  import triad_timer_pkg::*;
#(
  parameter int NUM   = 3,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM-1:0]            irq,
  input logic [NUM-1:0][CNT_W-1:0] cnt,
  input logic [NUM-1:0][EV_W-1:0]  sts,
  input logic [NUM-1:0][EV_W-1:0]  ier,
  input logic [NUM-1:0][EV_W-1:0]  evt,
  input logic [NUM-1:0][CFG_W-1:0] ctl,
  input logic [NUM-1:0]            tick,
  input logic [NUM-1:0]            we_ctl,
  input logic [NUM-1:0]            rd_sts,
  input logic                      restart_bit
);

  localparam logic [CNT_W-1:0] TOP = '1;

  for (genvar g = 0; g < NUM; g++) begin : g_chk
    AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
      (ctl[g][CT_HOLD] && !we_ctl[g]) |=> $stable(cnt[g])); // R3
    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
      (we_ctl[g] && restart_bit) |=> (cnt[g] == '0)); // R4
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
      (tick[g] && !ctl[g][CT_IVL] && cnt[g] == TOP && !we_ctl[g]) |=> (cnt[g] == '0 && sts[g][EV_OVF])); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (rd_sts[g] && evt[g] == '0) |=> (sts[g] == '0)); // R8
    AST_EVENT_SURVIVES_READ: assert property (@(posedge clk) disable iff (rst)
      (rd_sts[g] && evt[g][EV_IVL]) |=> sts[g][EV_IVL]); // R9
    AST_IRQ_FOLLOWS_STATE: assert property (@(posedge clk) disable iff (rst)
      irq[g] == |(sts[g] & ier[g])); // R10
  end

endmodule

bind triad_timer triad_timer_chk #(.NUM(NUM), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq         (irq),
  .cnt         (cnt_all),
  .sts         (sts_all),
  .ier         (ier_all),
  .evt         (evt_all),
  .ctl         (ctl_cfg_all),
  .tick        (tick_all),
  .we_ctl      (we_ctl),
  .rd_sts      (rd_sts),
  .restart_bit (bus_wdata[4])
);

// File: tb/triad_timer_bench.sv
module triad_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_VAL = 8'h18,
                         A_IVL = 8'h24, A_STS = 8'h54, A_IER = 8'h60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_edge = 0;
  int free_start = 0;

  triad_timer u_triad_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    last_edge = cyc;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    last_edge = cyc;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 32'(irq), 32'h0);
    bus_read(A_CTL, d);      check("R1 counter config reset", d, 32'h01);
    bus_read(A_CLK + 4, d);  check("R1 clock config reset", d, 32'h0);
    bus_read(A_STS + 8, d);  check("R1 pending reset", d, 32'h0);
    bus_read(8'h30, d);      check("R2 unmapped offset", d, 32'h0);
    repeat (20) @(negedge clk);
    bus_read(A_VAL, d);      check("R3 held after reset", d, 32'h0);
  endtask

  task automatic t_freerun();
    logic [31:0] d;
    bus_write(A_CTL + 4, 32'h10);
    free_start = last_edge;
    repeat (7) @(negedge clk);
    bus_read(A_VAL + 4, d);
    check("R5 undivided count", d, 32'(last_edge - 1 - free_start));
    bus_read(A_CTL + 4, d);
    check("R4 restart reads 0", d, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    int w;
    bus_write(A_CLK + 8, 32'h23);
    bus_write(A_CTL + 8, 32'h10);
    w = last_edge;
    repeat (21) @(negedge clk);
    bus_read(A_VAL + 8, d);
    check("R5 divide by 4", d, 32'((last_edge - 1 - w) / 4));
    bus_read(A_CLK + 8, d);
    check("R11 clock config with bit 5", d, 32'h23);
    bus_write(A_CLK + 8, 32'h01);
    bus_write(A_CTL + 8, 32'h10);
    w = last_edge;
    repeat (13) @(negedge clk);
    bus_read(A_VAL + 8, d);
    check("R5 divide by 2", d, 32'((last_edge - 1 - w) / 2));
    bus_write(A_CTL + 8, 32'h01);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    logic [31:0] exp;
    bus_write(A_CTL + 4, 32'h01);
    exp = 32'((last_edge - free_start) % 65536);
    bus_read(A_VAL + 4, d);  check("R3 stops at hold edge", d, exp);
    repeat (10) @(negedge clk);
    bus_read(A_VAL + 4, d);  check("R3 held value", d, exp);
    bus_write(A_VAL + 4, 32'h1234);
    bus_read(A_VAL + 4, d);  check("R12 count write ignored", d, exp);
    bus_write(A_CTL + 4, 32'h31);
    bus_read(A_CTL + 4, d);  check("R11 counter config bit 5 kept", d, 32'h21);
    bus_read(A_VAL + 4, d);  check("R4 restart while held", d, 32'h0);
  endtask

  task automatic t_interval();
    logic [31:0] d;
    int w;
    bus_write(A_IVL, 32'd5);
    bus_write(A_IER, 32'h1);
    bus_write(A_CTL, 32'h12);
    w = last_edge;
    while (irq[0] !== 1'b1 && cyc < w + 50) @(negedge clk);
    check("R7 interval event edge", 32'(cyc), 32'(w + 6));
    bus_read(A_STS, d);      check("R8 pending before clear", d, 32'h1);
    check("R10 irq drops with read", 32'(irq[0]), 32'h0);
    bus_read(A_STS, d);      check("R8 pending cleared", d, 32'h0);
    bus_read(A_VAL, d);      check("R7 count in interval", d, 32'((last_edge - 1 - w) % 6));
    while (cyc < w + 17) @(negedge clk);
    bus_read(A_STS, d);      check("R9 read on event edge", d, 32'h1);
    bus_read(A_STS, d);      check("R9 event kept after read", d, 32'h1);
    bus_read(A_STS, d);      check("R8 cleared after collision", d, 32'h0);
    bus_read(A_CTL, d);      check("R4 interval config readback", d, 32'h02);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(A_CLK + 8, 32'h0);
    bus_write(A_IVL + 8, 32'd3);
    bus_write(A_CTL + 8, 32'h12);
    repeat (10) @(negedge clk);
    check("R10 masked irq low", 32'(irq[2]), 32'h0);
    bus_read(A_STS + 8, d);  check("R7 masked pending set", d, 32'h1);
  endtask

  task automatic t_stride();
    logic [31:0] d;
    bus_write(A_IVL + 4, 32'h0777);
    bus_read(A_IVL, d);      check("R2 neighbour interval untouched", d, 32'd5);
    bus_read(A_IVL + 4, d);  check("R2 interval timer 1", d, 32'h0777);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    int w;
    int e;
    bus_write(A_IER + 4, 32'h2);
    bus_write(A_CLK + 4, 32'h0);
    bus_write(A_CTL + 4, 32'h10);
    w = last_edge;
    while (irq[1] !== 1'b1 && cyc < w + 70000) @(negedge clk);
    e = cyc;
    check("R6 wrap edge", 32'(e), 32'(w + 65536));
    bus_read(A_VAL + 4, d);  check("R6 count after wrap", d, 32'(last_edge - 1 - e));
    bus_read(A_STS + 4, d);  check("R6 overflow pending", d, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_freerun();
    t_prescale();
    t_hold();
    t_interval();
    t_mask();
    t_stride();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule